// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. A tester drives a test clock, a mode-select line and a serial data input, and reads a serial data output back. A sixteen-state controller steps through the standard scan sequence on each rising edge of the test clock. The mode-select line picks the next state. An instruction scan loads a 4-bit instruction. A data scan then shifts through one of three paths, chosen by the active instruction:

- a one-stage bypass flop;
- a 32-bit read-only identification word;
- an external boundary-scan chain, reached through a serial port and three strobes (capture, shift, update).

One instruction also raises a pin-disable signal, which floats every chip output. The controller can be reset in two ways: asynchronously by an active-low reset pin, or synchronously by holding the mode-select line high. Either reset makes the identification instruction active. A data scan straight after reset therefore reads the identification word.

State names used below:

- Reset: Test-Logic-Reset
- Idle: Run-Test/Idle
- Data-column states: DR-Select, DR-Capture, DR-Shift, DR-Exit1, DR-Pause, DR-Exit2, DR-Update
- Instruction-column states: IR-Select, IR-Capture, IR-Shift, IR-Exit1, IR-Pause, IR-Exit2, IR-Update

Transitions:

| State | Mode-select low | Mode-select high |
|---|---|---|
| Reset | Idle | Reset |
| Idle | Idle | DR-Select |
| DR-Select | DR-Capture | IR-Select |
| DR-Capture | DR-Shift | DR-Exit1 |
| DR-Shift | DR-Shift | DR-Exit1 |
| DR-Exit1 | DR-Pause | DR-Update |
| DR-Pause | DR-Pause | DR-Exit2 |
| DR-Exit2 | DR-Shift | DR-Update |
| DR-Update | Idle | DR-Select |
| IR-Select | IR-Capture | Reset |
| IR-Capture | IR-Shift | IR-Exit1 |
| IR-Shift | IR-Shift | IR-Exit1 |
| IR-Exit1 | IR-Pause | IR-Update |
| IR-Pause | IR-Pause | IR-Exit2 |
| IR-Exit2 | IR-Shift | IR-Update |
| IR-Update | Idle | DR-Select |

Top module: `scan_tap`

## Requirements
- R1: After the reset pin is asserted, the identification instruction (4'h2) is active. The serial output is disabled and the pin-disable output is low. A data scan then returns the identification word, bit 0 first, with no instruction scan needed.
- R2: With default parameters the identification word is 32'h004A9067. Bits [31:28] hold version 0. Bits [27:12] hold part 16'h04A9. Bits [11:1] hold maker code 11'h033. Bit 0 is 1.
- R3: Five rising edges with mode-select high reach Reset from any state. On reaching Reset, the active instruction becomes identification.
- R4: The state sequence follows the transition table above, including the pause and exit states of both columns. Re-entering Shift from a pause resumes the shift with no new capture.
- R5: In IR-Capture the instruction shift stage loads 4'b0001. In IR-Shift the stage shifts toward the output, so bit 0 leaves first.
- R6: The active instruction changes only at the rising edge that leaves IR-Update. While a new code is being shifted in, the pin-disable output and the data path do not change.
- R7: When the bypass stage is selected, it loads 0 in DR-Capture. In DR-Shift the serial output is then the serial input delayed by one test clock.
- R8: Instruction 4'h3 raises the pin-disable output and selects the bypass stage.
- R9: Instruction 4'h1 keeps the pin-disable output low. It pulses the chain capture, shift and update strobes in the matching DR states, passes the serial input to the chain, and shifts the chain's serial output to the pin.
- R10: Every code other than 4'h1, 4'h2 and 4'h3 behaves as bypass. This includes 4'h0 and 4'h7.
- R11: The serial output and its enable change only on falling edges of the test clock. The enable is high exactly while the controller is in IR-Shift or DR-Shift.
- R12: Instruction 4'hF selects the bypass stage and keeps the pin-disable output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| pin_disable | output | 1 | Floats all chip outputs when high |
| chain_si | output | 1 | Serial data into the boundary chain |
| chain_so | input | 1 | Serial data out of the boundary chain |
| chain_capture | output | 1 | Chain capture strobe |
| chain_shift | output | 1 | Chain shift strobe |
| chain_update | output | 1 | Chain update strobe |

## Verification
The bench loads each of the three implemented instruction codes, plus the bypass code and two unimplemented codes. After each load it runs a data scan with a distinct bit pattern. The result shows which of the three paths is wired: the identification word, a one-clock delayed copy of the input, or the preset chain contents. One identification read is split by a pause. This separates a correct resume from a stray recapture. Synchronous reset is applied from inside DR-Shift and from IR-Pause, and the asynchronous pin is pulled while the high-impedance instruction is active. Each of these must bring back the identification word and drop the pin-disable output.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPD
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_CHAIN
    } dr_path_t;

    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h1;
    localparam logic [IR_W-1:0] OP_IDENT   = 4'h2;
    localparam logic [IR_W-1:0] OP_FLOAT   = 4'h3;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic in_reset,
    output logic ir_cap,
    output logic ir_shift,
    output logic ir_upd,
    output logic dr_cap,
    output logic dr_shift,
    output logic dr_upd
);

    tap_state_t state_q, state_d;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    always_comb begin
        in_reset = (state_q == ST_RESET);
        ir_cap   = (state_q == ST_IR_CAP);
        ir_shift = (state_q == ST_IR_SHIFT);
        ir_upd   = (state_q == ST_IR_UPD);
        dr_cap   = (state_q == ST_DR_CAP);
        dr_shift = (state_q == ST_DR_SHIFT);
        dr_upd   = (state_q == ST_DR_UPD);
    end

    // count of consecutive mode-select-high edges, saturating at five
    logic [2:0] hi_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             hi_run_q <= 3'd0;
        else if (!tms)           hi_run_q <= 3'd0;
        else if (hi_run_q != 3'd5) hi_run_q <= hi_run_q + 3'd1;
    end

    assert_five_high_reset_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run_q == 3'd5) |-> (state_q == ST_RESET));

    assert_pause_resume_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_DR_EXIT2 && !tms) |=> (state_q == ST_DR_SHIFT));

    assert_capture_to_shift_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_IR_CAP && !tms) |=> (state_q == ST_IR_SHIFT));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  logic     in_reset,
    input  logic     cap,
    input  logic     shift,
    input  logic     upd,
    output logic     ir_so,
    output dr_path_t path,
    output logic     float_pins
);

    logic [IR_W-1:0] stage_q;
    logic [IR_W-1:0] active_q;
    logic [IR_W-1:0] op_eff;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stage_q  <= IR_CAPTURE;
            active_q <= OP_IDENT;
        end else begin
            if (in_reset) active_q <= OP_IDENT;
            else if (upd) active_q <= stage_q;
            if (cap)        stage_q <= IR_CAPTURE;
            else if (shift) stage_q <= {tdi, stage_q[IR_W-1:1]};
        end
    end

    assign ir_so  = stage_q[0];
    assign op_eff = in_reset ? OP_IDENT : active_q;

    always_comb begin
        path       = PATH_BYPASS;
        float_pins = 1'b0;
        case (op_eff)
            OP_IDENT:  path = PATH_IDENT;
            OP_SAMPLE: path = PATH_CHAIN;
            OP_FLOAT:  float_pins = 1'b1;
            default:   path = PATH_BYPASS;
        endcase
    end

    assert_capture_pattern_R5: assert property (@(posedge tck) disable iff (!trst_n)
        cap |=> (stage_q == IR_CAPTURE));

    assert_active_holds_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (!upd && !in_reset) |=> $stable(active_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              ID_W    = 32,
    parameter logic [ID_W-1:0] ID_WORD = '0
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  logic     cap,
    input  logic     shift,
    input  dr_path_t path,
    input  logic     chain_so,
    output logic     dr_so
);

    logic            byp_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
            id_q  <= ID_WORD;
        end else begin
            if (path == PATH_BYPASS) begin
                if (cap)        byp_q <= 1'b0;
                else if (shift) byp_q <= tdi;
            end
            if (path == PATH_IDENT) begin
                if (cap)        id_q <= ID_WORD;
                else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
            end
        end
    end

    always_comb begin
        unique case (path)
            PATH_IDENT: dr_so = id_q[0];
            PATH_CHAIN: dr_so = chain_so;
            default:    dr_so = byp_q;
        endcase
    end

    assert_bypass_zero_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_BYPASS) |=> (byp_q == 1'b0));

    assert_ident_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && path == PATH_IDENT) |=> (id_q == ID_WORD));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter logic [3:0]  VERSION = 4'h0,
    parameter logic [15:0] PART    = 16'h04A9,
    parameter logic [10:0] MAKER   = 11'h033
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic pin_disable,
    output logic chain_si,
    input  logic chain_so,
    output logic chain_capture,
    output logic chain_shift,
    output logic chain_update
);

    localparam int              ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART, MAKER, 1'b1};

    logic     in_reset, ir_cap, ir_shift, ir_upd, dr_cap, dr_shift, dr_upd;
    logic     ir_so, dr_so, float_pins;
    dr_path_t path;

    tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .in_reset (in_reset),
        .ir_cap   (ir_cap),
        .ir_shift (ir_shift),
        .ir_upd   (ir_upd),
        .dr_cap   (dr_cap),
        .dr_shift (dr_shift),
        .dr_upd   (dr_upd)
    );

    tap_ir u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .in_reset   (in_reset),
        .cap        (ir_cap),
        .shift      (ir_shift),
        .upd        (ir_upd),
        .ir_so      (ir_so),
        .path       (path),
        .float_pins (float_pins)
    );

    tap_dr #(.ID_W(ID_W), .ID_WORD(ID_WORD)) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .cap      (dr_cap),
        .shift    (dr_shift),
        .path     (path),
        .chain_so (chain_so),
        .dr_so    (dr_so)
    );

    assign pin_disable   = float_pins;
    assign chain_si      = tdi;
    assign chain_capture = dr_cap   && (path == PATH_CHAIN);
    assign chain_shift   = dr_shift && (path == PATH_CHAIN);
    assign chain_update  = dr_upd   && (path == PATH_CHAIN);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= ir_shift || dr_shift;
            tdo    <= ir_shift ? ir_so : dr_so;
        end
    end

    assert_enable_in_shift_R11: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (ir_shift || dr_shift));

    assert_float_needs_bypass_R8: assert property (@(posedge tck) disable iff (!trst_n)
        pin_disable |-> !(chain_capture || chain_shift || chain_update));

endmodule

// File: tb/test_scan_tap.sv
module test_scan_tap;

    localparam int TLR = 0, RTI = 1, DSEL = 2, DCAP = 3, DSH = 4, DEX1 = 5, DPAU = 6,
                   DEX2 = 7, DUPD = 8, ISEL = 9, ICAP = 10, ISH = 11, IEX1 = 12,
                   IPAU = 13, IEX2 = 14, IUPD = 15;
    localparam logic [31:0] ID_EXP = {4'h0, 16'h04A9, 11'h033, 1'b1};

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, pin_disable, chain_si, chain_capture, chain_shift, chain_update;
    logic [7:0] chain = 8'h00;
    logic chain_so;
    assign chain_so = chain[0];

    always #4 tck = ~tck;

    scan_tap i_scan_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_disable(pin_disable), .chain_si(chain_si), .chain_so(chain_so),
        .chain_capture(chain_capture), .chain_shift(chain_shift), .chain_update(chain_update)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_req = "R1";

    int ms = TLR;
    logic [3:0] m_ir = 4'h2;
    bit irq[$];
    bit drq[$];
    logic last_tdo, last_en;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
        end
    endtask

    function automatic int nxt(int s, bit t);
        case (s)
            TLR:  return t ? TLR  : RTI;
            RTI:  return t ? DSEL : RTI;
            DSEL: return t ? ISEL : DCAP;
            DCAP: return t ? DEX1 : DSH;
            DSH:  return t ? DEX1 : DSH;
            DEX1: return t ? DUPD : DPAU;
            DPAU: return t ? DEX2 : DPAU;
            DEX2: return t ? DUPD : DSH;
            DUPD: return t ? DSEL : RTI;
            ISEL: return t ? TLR  : ICAP;
            ICAP: return t ? IEX1 : ISH;
            ISH:  return t ? IEX1 : ISH;
            IEX1: return t ? IUPD : IPAU;
            IPAU: return t ? IEX2 : IPAU;
            IEX2: return t ? IUPD : ISH;
            default: return t ? DSEL : RTI;
        endcase
    endfunction

    function automatic logic [3:0] dec();
        if (ms == TLR) return 4'h2;
        if (m_ir == 4'h1 || m_ir == 4'h2 || m_ir == 4'h3) return m_ir;
        return 4'hF;
    endfunction

    task automatic model_edge(bit t, bit d);
        logic [3:0] op;
        op = dec();
        case (ms)
            TLR:  m_ir = 4'h2;
            ICAP: irq = '{1'b1, 1'b0, 1'b0, 1'b0};
            ISH:  begin void'(irq.pop_front()); irq.push_back(d); end
            IUPD: m_ir = {irq[3], irq[2], irq[1], irq[0]};
            DCAP: begin
                drq.delete();
                if (op == 4'h2) for (int i = 0; i < 32; i++) drq.push_back(ID_EXP[i]);
                else if (op == 4'h1) chain = 8'hA5;
                else drq.push_back(1'b0);
            end
            DSH: begin
                if (op == 4'h1) chain = {d, chain[7:1]};
                else begin void'(drq.pop_front()); drq.push_back(d); end
            end
            default: ;
        endcase
        ms = nxt(ms, t);
    endtask

    task automatic compare();
        logic [3:0] op;
        bit sh;
        op = dec();
        sh = (ms == ISH) || (ms == DSH);
        chk("R11", "tdo_en", tdo_en, sh);
        if (sh) begin
            if (ms == ISH) chk(cur_req, "tdo ir", tdo, irq[0]);
            else if (op == 4'h1) chk(cur_req, "tdo chain", tdo, chain[0]);
            else chk(cur_req, "tdo dr", tdo, drq[0]);
        end
        chk("R8", "pin_disable", pin_disable, op == 4'h3);
        chk("R9", "chain_capture", chain_capture, ms == DCAP && op == 4'h1);
        chk("R9", "chain_shift", chain_shift, ms == DSH && op == 4'h1);
        chk("R9", "chain_update", chain_update, ms == DUPD && op == 4'h1);
        chk("R9", "chain_si", chain_si, tdi);
        last_tdo = tdo;
        last_en  = tdo_en;
    endtask

    task automatic step(bit t, bit d);
        tms = t; tdi = d;
        @(posedge tck);
        model_edge(t, d);
        #1;
        chk("R11", "tdo steady at rise", tdo, last_tdo);
        chk("R11", "tdo_en steady at rise", tdo_en, last_en);
        @(negedge tck);
        #1;
        compare();
    endtask

    task automatic pin_reset();
        trst_n = 1'b0;
        ms = TLR; m_ir = 4'h2;
        irq = '{1'b1, 1'b0, 1'b0, 1'b0};
        @(posedge tck); @(negedge tck); #1;
        chk("R1", "tdo_en in reset", tdo_en, 1'b0);
        chk("R1", "pin_disable in reset", pin_disable, 1'b0);
        last_tdo = tdo; last_en = tdo_en;
        trst_n = 1'b1;
    endtask

    task automatic dr_scan(int n, logic [31:0] din, bit pause, output logic [31:0] dout);
        step(1, 0); step(0, 0); step(0, 0);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            bit last;
            last = (i == n - 1);
            dout[i] = tdo;
            if (pause && i == 2 && !last) begin
                step(1, din[i]); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end else begin
                step(last, din[i]);
            end
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic ir_scan(logic [3:0] code, output logic [3:0] got);
        logic old_pd;
        old_pd = pin_disable;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            got[i] = tdo;
            step(i == 3, code[i]);
        end
        chk("R6", "pin_disable before update", pin_disable, old_pd);
        step(1, 0);
        chk("R6", "pin_disable in IR-Update", pin_disable, old_pd);
        step(0, 0);
    endtask

    initial begin
        #(8 * 60000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act hung exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  c;
        last_tdo = 1'b0; last_en = 1'b0;
        irq = '{1'b1, 1'b0, 1'b0, 1'b0};
        #5;
        pin_reset();
        step(0, 0);

        cur_req = "R1";   // R1 and R2: identification read straight after reset
        dr_scan(32, 32'hDEADBEEF, 0, d);
        chk("R2", "ident word", d, ID_EXP);

        cur_req = "R5";
        ir_scan(4'h3, c);
        chk("R5", "IR capture pattern", c, 4'b0001);
        chk("R8", "float pins after load", pin_disable, 1'b1);
        cur_req = "R7";
        dr_scan(8, 32'hB2, 0, d);
        chk("R7", "bypass delay under float", d[7:0], 8'h64);

        cur_req = "R12";
        ir_scan(4'hF, c);
        chk("R12", "pins enabled", pin_disable, 1'b0);
        dr_scan(8, 32'h5A, 0, d);
        chk("R12", "bypass delay", d[7:0], 8'hB4);

        cur_req = "R10";
        ir_scan(4'h0, c);
        dr_scan(8, 32'hC3, 0, d);
        chk("R10", "code 0 as bypass", d[7:0], 8'h86);
        ir_scan(4'h7, c);
        dr_scan(8, 32'h81, 0, d);
        chk("R10", "code 7 as bypass", d[7:0], 8'h02);

        cur_req = "R9";
        ir_scan(4'h1, c);
        chk("R9", "sample keeps pins", pin_disable, 1'b0);
        dr_scan(8, 32'h3C, 0, d);
        chk("R9", "chain read", d[7:0], 8'hA5);
        chk("R9", "chain loaded from tdi", chain, 8'h3C);

        cur_req = "R4";
        ir_scan(4'h2, c);
        dr_scan(32, 32'h0, 1, d);
        chk("R4", "ident read across pause", d, ID_EXP);

        cur_req = "R3";
        ir_scan(4'h3, c);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R3", "reset from DR-Shift", ms, TLR);
        chk("R3", "pins after tms reset", pin_disable, 1'b0);
        step(0, 0);
        dr_scan(32, 32'h0, 0, d);
        chk("R3", "ident after tms reset", d, ID_EXP);
        ir_scan(4'hF, c);
        step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R3", "reset from IR-Pause", ms, TLR);
        step(0, 0);

        cur_req = "R1";
        ir_scan(4'h3, c);
        pin_reset();
        step(0, 0);
        dr_scan(32, 32'h0, 0, d);
        chk("R1", "ident after pin reset", d, ID_EXP);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule